// File: doc/BRIEF.md
# Strided Transfer Descriptor Generator

This block turns a rectangular two-dimensional copy request into a linked chain of scatter-gather descriptors. A request names a host start address, a device start address, the number of bytes per line, the number of lines, a host stride and a two's-complement device stride. The block validates the request and rejects it with an error code if it breaks a size, stride or alignment rule. Otherwise it walks the rectangle line by line. It cuts every line wherever the host address would cross a 4096-byte page, and emits one descriptor per resulting segment.

Work on an accepted request takes two passes. A count pass walks every segment without touching memory and publishes the descriptor total. A write pass then walks the same segments again and writes one 128-bit descriptor per cycle into a descriptor memory owned by the block. Descriptors are linked backwards. The first one written carries the end-of-chain marker, and each later one points at its predecessor. Every next field is therefore final at the moment it is written, and the last descriptor written becomes the chain head handed to the DMA engine.

Top module: `stride_desc_gen`

## Requirements
- R1: After reset, busy, done, mem_we, err_code, desc_count and chain_head are all zero.
- R2: Each descriptor is written as one 128-bit word. Bits [31:0] hold the host address, [63:32] the device address, [95:64] the byte count and [127:96] the next pointer.
- R3: A segment's byte count is the smaller of the bytes left in the current line and 4096 minus the low 12 bits of the segment's host address. Segments are emitted line by line in address order.
- R4: Within a line, the host and device addresses of consecutive segments advance by the previous segment's byte count. Each new line starts at the previous line's start plus the host stride on the host side, and plus the device stride on the device side. A negative device stride walks the device side downward.
- R5: The descriptor at index 0 has next pointer 0x00000002 (bit 1 marks end of chain). The descriptor at index i>0 has next pointer desc_base + 16*(i-1). At done, chain_head equals desc_base + 16*(N-1).
- R6: desc_count reaches the final descriptor total N before the first memory write. Writes then use indices 0..N-1 on consecutive cycles, exactly N writes in all.
- R7: Size errors give err_code 1: line count 0, line count above 2048, or line length 0.
- R8: Stride errors give err_code 2: host stride above 8192, host stride below the line length, host stride minus line length of 4096 or more, or device stride magnitude below the line length.
- R9: Alignment errors give err_code 3: a host address or host stride that is not a multiple of 16, or a device address or device stride that is not a multiple of 4. When several classes fail, size wins over stride and stride wins over alignment.
- R10: A rejected request produces done with its error code, no memory write and desc_count 0. An accepted request ends with err_code 0.
- R11: busy is high from the clock edge after start until done. done is a one-cycle pulse with busy low. start and the request inputs have no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a request (sampled only when idle) |
| req_host | input | 32 | Host start address |
| req_dev | input | 32 | Device start address |
| req_len | input | LEN_W | Bytes per line |
| req_lines | input | LINE_W | Number of lines |
| req_hstride | input | HSTR_W | Host stride in bytes |
| req_dstride | input | 32 | Device stride, two's complement |
| desc_base | input | 32 | Byte address of descriptor index 0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 size, 2 stride, 3 alignment |
| desc_count | output | CNT_W | Descriptor total from the count pass |
| chain_head | output | 32 | Byte address of the last descriptor written |
| mem_we | output | 1 | Descriptor memory write enable |
| mem_idx | output | CNT_W | Descriptor index being written |
| mem_wdata | output | 128 | Descriptor contents |

## Verification
Random requests place host starts at arbitrary 16-byte offsets inside a page, with line lengths from a few bytes up to about 6000. Whether a line yields one, two or three segments therefore varies, which separates correct page splitting from splitting on line boundaries alone. Positive and negative device strides tell a correct signed device walk apart from one that treats the stride as unsigned. Directed cases hit the exact boundaries: a page-aligned line of 4096 bytes, a line starting 16 bytes before a page end, the largest legal line count, and each rejection rule at its threshold. These are joined by mixed violations that expose the error priority and by a start pulse with altered inputs mid-run, which must leave the chain unchanged.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    localparam int          PAGE_W       = 12;
    localparam logic [31:0] PAGE_BYTES   = 32'd4096;
    localparam logic [31:0] MAX_LINES    = 32'd2048;
    localparam logic [31:0] MAX_HSTRIDE  = 32'd8192;
    localparam logic [31:0] EOC_MARK     = 32'h0000_0002;
    localparam int          DESC_SHIFT   = 4;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SIZE   = 2'd1,
        ERR_STRIDE = 2'd2,
        ERR_ALIGN  = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_COUNT,
        ST_WRITE
    } state_e;

    typedef struct packed {
        logic [31:0] next;
        logic [31:0] count;
        logic [31:0] dev;
        logic [31:0] host;
    } desc_t;

    function automatic logic [31:0] page_room(input logic [31:0] addr);
        return PAGE_BYTES - 32'(addr[PAGE_W-1:0]);
    endfunction

    function automatic logic [31:0] mag32(input logic [31:0] v);
        return v[31] ? (~v + 32'd1) : v;
    endfunction

endpackage

// File: rtl/sdg_check.sv
module sdg_check
    import sdg_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int LEN_W  = 16,
    parameter int HSTR_W = 16
) (
    input  logic [31:0]       host,
    input  logic [31:0]       dev,
    input  logic [LEN_W-1:0]  len,
    input  logic [LINE_W-1:0] lines,
    input  logic [HSTR_W-1:0] hstride,
    input  logic [31:0]       dstride,
    output err_e              err
);
    logic [31:0] len32, hs32, lines32;
    logic size_bad, stride_bad, align_bad;

    always_comb begin
        len32   = 32'(len);
        hs32    = 32'(hstride);
        lines32 = 32'(lines);
        size_bad   = (lines32 == 32'd0) || (lines32 > MAX_LINES) || (len32 == 32'd0);
        stride_bad = (hs32 > MAX_HSTRIDE) || (hs32 < len32) ||
                     ((hs32 >= len32) && ((hs32 - len32) >= PAGE_BYTES)) ||
                     (mag32(dstride) < len32);
        align_bad  = (host[3:0] != 4'd0) || (hstride[3:0] != 4'd0) ||
                     (dev[1:0] != 2'd0) || (dstride[1:0] != 2'd0);
        if (size_bad)        err = ERR_SIZE;
        else if (stride_bad) err = ERR_STRIDE;
        else if (align_bad)  err = ERR_ALIGN;
        else                 err = ERR_NONE;
    end
endmodule

// File: rtl/sdg_walker.sv
module sdg_walker
    import sdg_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int LEN_W  = 16,
    parameter int HSTR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [31:0]       host0,
    input  logic [31:0]       dev0,
    input  logic [LEN_W-1:0]  len,
    input  logic [LINE_W-1:0] lines,
    input  logic [HSTR_W-1:0] hstride,
    input  logic [31:0]       dstride,
    output logic [31:0]       seg_host,
    output logic [31:0]       seg_dev,
    output logic [31:0]       seg_len,
    output logic              last
);
    logic [31:0]       cur_host, cur_dev, line_host, line_dev;
    logic [LEN_W-1:0]  rem;
    logic [LINE_W-1:0] left;
    logic [31:0]       room, rem32, nxt_lhost, nxt_ldev;
    logic              line_end;

    always_comb begin
        room      = page_room(cur_host);
        rem32     = 32'(rem);
        seg_len   = (rem32 < room) ? rem32 : room;
        line_end  = (rem32 <= room);
        last      = line_end && (left == LINE_W'(1));
        seg_host  = cur_host;
        seg_dev   = cur_dev;
        nxt_lhost = line_host + 32'(hstride);
        nxt_ldev  = line_dev + dstride;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_host  <= '0;
            cur_dev   <= '0;
            line_host <= '0;
            line_dev  <= '0;
            rem       <= '0;
            left      <= '0;
        end else if (load) begin
            cur_host  <= host0;
            cur_dev   <= dev0;
            line_host <= host0;
            line_dev  <= dev0;
            rem       <= len;
            left      <= lines;
        end else if (step) begin
            if (line_end) begin
                line_host <= nxt_lhost;
                line_dev  <= nxt_ldev;
                cur_host  <= nxt_lhost;
                cur_dev   <= nxt_ldev;
                rem       <= len;
                left      <= left - LINE_W'(1);
            end else begin
                cur_host <= cur_host + seg_len;
                cur_dev  <= cur_dev + seg_len;
                rem      <= rem - LEN_W'(seg_len);
            end
        end
    end

    AST_SEG_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        step |-> (seg_len != 32'd0) && ((32'(cur_host[PAGE_W-1:0]) + seg_len) <= PAGE_BYTES)); // R3

    AST_SEG_FITS_LINE: assert property (@(posedge clk) disable iff (rst)
        step |-> (seg_len <= 32'(len)) && (left != '0)); // R3

endmodule

// File: rtl/stride_desc_gen.sv
module stride_desc_gen
    import sdg_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int LEN_W  = 16,
    parameter int HSTR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       req_host,
    input  logic [31:0]       req_dev,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [LINE_W-1:0] req_lines,
    input  logic [HSTR_W-1:0] req_hstride,
    input  logic [31:0]       req_dstride,
    input  logic [31:0]       desc_base,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [CNT_W-1:0]  desc_count,
    output logic [31:0]       chain_head,
    output logic              mem_we,
    output logic [CNT_W-1:0]  mem_idx,
    output logic [127:0]      mem_wdata
);
    state_e            state;
    err_e              err_q, chk_err;
    logic [31:0]       r_host, r_dev, r_dstride, r_base;
    logic [LEN_W-1:0]  r_len;
    logic [LINE_W-1:0] r_lines;
    logic [HSTR_W-1:0] r_hstride;
    logic [CNT_W-1:0]  cnt_q, widx_q;
    logic [31:0]       head_q, this_addr;
    logic [31:0]       seg_host, seg_dev, seg_len;
    logic              seg_last, wk_load, wk_step;
    desc_t             desc;

    sdg_check #(.LINE_W(LINE_W), .LEN_W(LEN_W), .HSTR_W(HSTR_W)) u_check (
        .host(r_host), .dev(r_dev), .len(r_len), .lines(r_lines),
        .hstride(r_hstride), .dstride(r_dstride), .err(chk_err)
    );

    assign wk_load = ((state == ST_CHECK) && (chk_err == ERR_NONE)) ||
                     ((state == ST_COUNT) && seg_last);
    assign wk_step = (state == ST_COUNT) || (state == ST_WRITE);

    sdg_walker #(.LINE_W(LINE_W), .LEN_W(LEN_W), .HSTR_W(HSTR_W)) u_walk (
        .clk(clk), .rst(rst), .load(wk_load), .step(wk_step),
        .host0(r_host), .dev0(r_dev), .len(r_len), .lines(r_lines),
        .hstride(r_hstride), .dstride(r_dstride),
        .seg_host(seg_host), .seg_dev(seg_dev), .seg_len(seg_len), .last(seg_last)
    );

    always_comb begin
        this_addr  = r_base + (32'(widx_q) << DESC_SHIFT);
        desc.host  = seg_host;
        desc.dev   = seg_dev;
        desc.count = seg_len;
        desc.next  = (widx_q == '0) ? EOC_MARK
                                    : (this_addr - (32'd1 << DESC_SHIFT));
    end

    assign busy       = (state != ST_IDLE);
    assign mem_we     = (state == ST_WRITE);
    assign mem_idx    = widx_q;
    assign mem_wdata  = desc;
    assign err_code   = err_q;
    assign desc_count = cnt_q;
    assign chain_head = head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            done      <= 1'b0;
            err_q     <= ERR_NONE;
            cnt_q     <= '0;
            widx_q    <= '0;
            head_q    <= '0;
            r_host    <= '0;
            r_dev     <= '0;
            r_len     <= '0;
            r_lines   <= '0;
            r_hstride <= '0;
            r_dstride <= '0;
            r_base    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    r_host    <= req_host;
                    r_dev     <= req_dev;
                    r_len     <= req_len;
                    r_lines   <= req_lines;
                    r_hstride <= req_hstride;
                    r_dstride <= req_dstride;
                    r_base    <= desc_base;
                    state     <= ST_CHECK;
                end
                ST_CHECK: begin
                    err_q  <= chk_err;
                    cnt_q  <= '0;
                    widx_q <= '0;
                    head_q <= '0;
                    if (chk_err != ERR_NONE) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (seg_last) state <= ST_WRITE;
                end
                ST_WRITE: begin
                    widx_q <= widx_q + CNT_W'(1);
                    head_q <= this_addr;
                    if (seg_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_WR_BELOW_COUNT: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_idx < desc_count)); // R6

    AST_WR_CONSECUTIVE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_idx == $past(mem_idx) + CNT_W'(1))); // R6

    AST_LINK_TO_HEAD: assert property (@(posedge clk) disable iff (rst)
        (mem_we && (mem_idx != '0)) |-> (mem_wdata[127:96] == chain_head)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11

    AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (err_code != 2'd0) |-> !mem_we); // R10

endmodule

// File: tb/sim_stride_desc_gen.sv
module sim_stride_desc_gen;
    localparam int CLK_PERIOD = 10;
    localparam int MAXD       = 8192;
    localparam int SEED       = 20240611;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [31:0]  req_host = '0, req_dev = '0, req_dstride = '0, desc_base = '0;
    logic [15:0]  req_len = '0;
    logic [11:0]  req_lines = '0;
    logic [15:0]  req_hstride = '0;
    logic         busy, done, mem_we;
    logic [1:0]   err_code;
    logic [15:0]  desc_count, mem_idx;
    logic [31:0]  chain_head;
    logic [127:0] mem_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    stride_desc_gen u0 (
        .clk(clk), .rst(rst), .start(start),
        .req_host(req_host), .req_dev(req_dev), .req_len(req_len),
        .req_lines(req_lines), .req_hstride(req_hstride), .req_dstride(req_dstride),
        .desc_base(desc_base), .busy(busy), .done(done), .err_code(err_code),
        .desc_count(desc_count), .chain_head(chain_head),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [31:0] exp_host [MAXD];
    logic [31:0] exp_dev  [MAXD];
    logic [31:0] exp_len  [MAXD];
    int          exp_n;
    logic [127:0] cap [MAXD];
    int          wr_seen;
    int          first_cnt;
    int          bad_idx;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (wr_seen == 0) first_cnt = int'(desc_count);
            if (int'(mem_idx) != wr_seen) bad_idx++;
            if (int'(mem_idx) < MAXD) cap[mem_idx] = mem_wdata;
            wr_seen++;
        end
    end

    function automatic int ref_err(input logic [31:0] h, input logic [31:0] d,
                                   input int len, input int lines, input int hs,
                                   input int ds);
        int dmag;
        dmag = (ds < 0) ? -ds : ds;
        if (lines == 0 || lines > 2048 || len == 0) return 1;
        if (hs > 8192 || hs < len || (hs - len) >= 4096 || dmag < len) return 2;
        if (h[3:0] != 0 || (hs % 16) != 0 || d[1:0] != 0 || (ds % 4) != 0) return 3;
        return 0;
    endfunction

    task automatic build_model(input logic [31:0] h0, input logic [31:0] d0,
                               input int len, input int lines, input int hs,
                               input int ds);
        logic [31:0] lh, ld, h, d;
        int rem, room, s, n;
        n = 0;
        lh = h0;
        ld = d0;
        for (int l = 0; l < lines; l++) begin
            rem = len;
            h = lh;
            d = ld;
            while (rem > 0) begin
                room = 4096 - int'(h & 32'hFFF);
                s = (rem < room) ? rem : room;
                if (n < MAXD) begin
                    exp_host[n] = h;
                    exp_dev[n]  = d;
                    exp_len[n]  = 32'(s);
                end
                n++;
                h = h + 32'(s);
                d = d + 32'(s);
                rem = rem - s;
            end
            lh = lh + 32'(hs);
            ld = ld + 32'(ds);
        end
        exp_n = n;
    endtask

    task automatic run_req(input logic [31:0] h, input logic [31:0] d, input int len,
                           input int lines, input int hs, input int ds,
                           input logic [31:0] base, input bit poke);
        int eerr, k;
        bit ok_h, ok_d, ok_l, ok_n;
        logic [31:0] exp_next, a_h, a_d, a_l, a_n, e_h, e_d, e_l, e_n;
        eerr = ref_err(h, d, len, lines, hs, ds);
        if (eerr == 0) build_model(h, d, len, lines, hs, ds);
        else exp_n = 0;
        @(negedge clk);
        req_host    = h;
        req_dev     = d;
        req_len     = 16'(len);
        req_lines   = 12'(lines);
        req_hstride = 16'(hs);
        req_dstride = 32'(ds);
        desc_base   = base;
        wr_seen     = 0;
        first_cnt   = -1;
        bad_idx     = 0;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", "busy after start", 32'(busy), 32'd1);
        k = 0;
        while (!done && k < 100000) begin
            @(negedge clk);
            k++;
            if (poke && k == 2) begin
                start       = 1'b1;
                req_lines   = 12'd0;
                req_host    = h + 32'h100;
                desc_base   = base + 32'h40;
            end
            if (poke && k == 3) start = 1'b0;
        end
        check(done == 1'b1, "R11", "done seen", 32'(done), 32'd1);
        check(busy == 1'b0, "R11", "busy low at done", 32'(busy), 32'd0);
        check(int'(err_code) == eerr,
              (eerr == 1) ? "R7" : (eerr == 2) ? "R8" : (eerr == 3) ? "R9" : "R10",
              "err_code", 32'(err_code), 32'(eerr));
        if (eerr != 0) begin
            check(wr_seen == 0, "R10", "writes on rejected request", 32'(wr_seen), 32'd0);
            check(desc_count == 16'd0, "R10", "desc_count on reject", 32'(desc_count), 32'd0);
        end else begin
            check(first_cnt == exp_n, "R6", "count before first write", 32'(first_cnt), 32'(exp_n));
            check(wr_seen == exp_n && bad_idx == 0, "R6", "write total/order",
                  32'(wr_seen), 32'(exp_n));
            check(int'(desc_count) == exp_n, "R6", "desc_count", 32'(desc_count), 32'(exp_n));
            ok_h = 1; ok_d = 1; ok_l = 1; ok_n = 1;
            a_h = 0; a_d = 0; a_l = 0; a_n = 0; e_h = 0; e_d = 0; e_l = 0; e_n = 0;
            for (int i = 0; i < exp_n && i < MAXD; i++) begin
                exp_next = (i == 0) ? 32'h2 : (base + 32'((i - 1) * 16));
                if (ok_h && cap[i][31:0] != exp_host[i]) begin
                    ok_h = 0; a_h = cap[i][31:0]; e_h = exp_host[i];
                end
                if (ok_d && cap[i][63:32] != exp_dev[i]) begin
                    ok_d = 0; a_d = cap[i][63:32]; e_d = exp_dev[i];
                end
                if (ok_l && cap[i][95:64] != exp_len[i]) begin
                    ok_l = 0; a_l = cap[i][95:64]; e_l = exp_len[i];
                end
                if (ok_n && cap[i][127:96] != exp_next) begin
                    ok_n = 0; a_n = cap[i][127:96]; e_n = exp_next;
                end
            end
            check(ok_h, "R4", "host address field (R2 lane 0)", a_h, e_h);
            check(ok_d, "R4", "device address field (R2 lane 1)", a_d, e_d);
            check(ok_l, "R3", "segment byte count (R2 lane 2)", a_l, e_l);
            check(ok_n, "R5", "next pointer (R2 lane 3)", a_n, e_n);
            check(chain_head == base + 32'((exp_n - 1) * 16), "R5", "chain head",
                  chain_head, base + 32'((exp_n - 1) * 16));
        end
        @(negedge clk);
        check(done == 1'b0, "R11", "done is one cycle", 32'(done), 32'd0);
        if (poke)
            check(busy == 1'b0 && wr_seen == exp_n, "R11", "start while busy ignored",
                  32'(wr_seen), 32'(exp_n));
    endtask

    initial begin
        int len, lines, hs, ds, lr16, lr4;
        logic [31:0] h, d, b;
        void'($urandom(SEED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_we, "R1", "control outputs after reset",
              {29'd0, busy, done, mem_we}, 32'd0);
        check(err_code == 2'd0 && desc_count == 16'd0 && chain_head == 32'd0, "R1",
              "status outputs after reset", chain_head | 32'(desc_count) | 32'(err_code), 32'd0);

        run_req(32'h0001_0000, 32'h0800_0000, 4096, 3, 4096, 4096, 32'h2000_0000, 0);
        run_req(32'h0002_0FF0, 32'h0900_0100, 32, 2, 4096, 64, 32'h2000_1000, 0);
        run_req(32'h0003_0010, 32'h0A00_0000, 8192, 2, 8192, -8192, 32'h2100_0000, 0);
        run_req(32'h0004_0800, 32'h0B00_4000, 100, 4, 112, -104, 32'h2200_0000, 0);
        run_req(32'h0005_0000, 32'h0C00_0000, 16, 2048, 16, 16, 32'h3000_0000, 0);
        run_req(32'h0006_0FE0, 32'h0D00_0000, 200, 3, 208, 200, 32'h3100_0000, 1);

        run_req(32'h0001_0000, 32'h0, 64, 0, 64, 64, 32'h0, 0);
        run_req(32'h0001_0000, 32'h0, 64, 2049, 64, 64, 32'h0, 0);
        run_req(32'h0001_0000, 32'h0, 0, 4, 64, 64, 32'h0, 0);
        run_req(32'h0001_0000, 32'h0, 64, 4, 8208, 64, 32'h0, 0);
        run_req(32'h0001_0000, 32'h0, 128, 4, 64, 128, 32'h0, 0);
        run_req(32'h0001_0000, 32'h0, 16, 4, 4112, 16, 32'h0, 0);
        run_req(32'h0001_0000, 32'h0, 64, 4, 64, -60, 32'h0, 0);
        run_req(32'h0001_0008, 32'h0, 64, 4, 64, 64, 32'h0, 0);
        run_req(32'h0001_0000, 32'h0, 64, 4, 64, 66, 32'h0, 0);
        run_req(32'h0001_0008, 32'h1, 64, 0, 64, 66, 32'h0, 0);
        run_req(32'h0001_0008, 32'h1, 64, 3, 32, 66, 32'h0, 0);

        for (int t = 0; t < 30; t++) begin
            lines = 1 + int'($urandom % 5);
            len   = 1 + int'($urandom % 6000);
            lr16  = ((len + 15) / 16) * 16;
            lr4   = ((len + 3) / 4) * 4;
            hs    = lr16 + 16 * int'($urandom % 8);
            if (hs > 8192) hs = lr16;
            ds    = lr4 + 4 * int'($urandom % 16);
            if ($urandom % 2 == 1) ds = -ds;
            h = $urandom & 32'hFFFF_FFF0;
            d = $urandom & 32'hFFFF_FFFC;
            b = $urandom & 32'hFFFF_FFF0;
            run_req(h, d, len, lines, hs, ds, b, 0);
        end
        finish_run();
    end
endmodule